// File: doc/BRIEF.md
# Paged DMA Address Translator

This block is a multi-channel DMA engine that carries a device transfer request (channel, byte length, direction) into physical memory traffic. Each channel has its own logical start address and byte budget in a small register file. The engine walks a page table that sits in memory: for every 4 KiB logical page it touches, it fetches an 8-byte entry whose first word is the physical frame. It then issues one physical access that never crosses the page. When the transfer ends it updates the channel's status flags and remaining byte count.

Requests enter on a valid/ready pair. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle, so a requester keeps `req_valid` and its fields steady until then. Memory is reached through a request/grant port. `mem_req` and its fields stay constant until `mem_gnt`. Exactly one `mem_rvalid` pulse per grant answers it, in a later cycle. Each request ends with a one-cycle `done` pulse that reports the bytes moved and whether it was aborted.

Top module: `pgdma_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `done` and `mem_req` are 0, every register reads 0 and `nmi_src` is 0.
- R2: Register map (byte offsets; address bits 2:0 ignored): table base at 0x040, table limit at 0x048, read-only error-source bits at 0x050. Channel n, word k sits at 0x100 + 32·n + 8·k, with k=0 a spare word, k=1 control, k=2 count and k=3 logical address. Every writable register reads back what was written.
- R3: A request is accepted only when `req_ready` is 1. `req_ready` stays 0 from acceptance through the `done` cycle. A `req_valid` raised while busy has no effect on any channel.
- R4: At the start of a request, control bits 8, 9 and 10 are cleared. If control bit 0 (enable) is 0, or `req_write` (1 = device to memory) equals control bit 1 (1 = memory to device), the request is rejected. Bit 9 is set, `nmi_src[n]` is set and stays set, no memory access is made, and `done` reports 0 bytes with `done_abort`=1.
- R5: The transfer length is the smaller of `req_len` and the channel's count. On normal completion control bit 8 is set and the count drops by the bytes moved. A zero length completes with no memory access.
- R6: For logical page index i = address/4096, the entry is fetched with `mem_fetch`=1, `mem_we`=0 and `mem_len`=8. Its address is (base + 8·i) with bit 31 cleared. `mem_rdata` of the reply is the frame address.
- R7: Each data access has address frame + (logical address mod 4096), and length min(4096 − offset, bytes left). `mem_fetch` is 0 and `mem_we` equals `req_write`. The logical address then advances by that length.
- R8: If i ≥ limit/8 when a page is reached, no further bytes move. The transfer still completes normally: bit 8 is set and the count drops only by the bytes already moved.
- R9: A reply with `mem_rerr`=1 to a table fetch aborts the transfer. Control bit 10 is set, bit 8 stays clear, the count is unchanged, and `done_abort`=1 with `done_bytes` giving the bytes moved before it. An error on a data access is not acted on.
- R10: `done` is a single-cycle pulse after the last access, limit stop, rejection or abort.
- R11: While `mem_req` is 1 and `mem_gnt` is 0, `mem_req`, `mem_addr`, `mem_len`, `mem_fetch` and `mem_we` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_chan | input | 3 | Channel number |
| req_len | input | 32 | Requested byte length |
| req_write | input | 1 | 1 = device to memory, 0 = memory to device |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_fetch | output | 1 | 1 = table entry fetch, 0 = data access |
| mem_we | output | 1 | Data access writes memory |
| mem_addr | output | 32 | Physical byte address |
| mem_len | output | 13 | Access length in bytes |
| mem_rvalid | input | 1 | Completion of the granted access |
| mem_rerr | input | 1 | Completion carries an error |
| mem_rdata | input | 32 | Frame word of a fetched entry |
| done | output | 1 | One-cycle end-of-request pulse |
| done_bytes | output | 32 | Bytes moved, valid with `done` |
| done_abort | output | 1 | Request rejected or aborted, valid with `done` |
| nmi_src | output | 8 | Sticky per-channel rejection bits |

## Verification
A transfer that fits inside one page shows that the entry index and the offset are handled separately. A transfer that starts near the end of a page, spans three pages and is clamped by the count register separates the head, full-page and tail chunk lengths. It also shows clamping to the smaller of length and count. A table limit that cuts a transfer short tells a partial count update apart from a full one. An error on the second fetch, with the base placed above bit 31, tells the abort path from the limit path and shows that the entry address is masked. Disabled and wrong-direction requests, a zero length and a request raised while busy cover the paths on which nothing moves.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;
  localparam int REG_AW      = 9;
  localparam int OFF_TBASE   = 'h040;
  localparam int OFF_TLIMIT  = 'h048;
  localparam int OFF_ERRSRC  = 'h050;
  localparam int CH_BASE     = 'h100;
  localparam int CH_STRIDE_B = 5;     // 32 bytes per channel block
  localparam int ENTRY_BYTES = 8;

  // control register bit positions
  localparam int CB_EN   = 0;
  localparam int CB_M2D  = 1;
  localparam int CB_TC   = 8;
  localparam int CB_MERR = 9;
  localparam int CB_AERR = 10;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_PAGE, S_FETCH, S_FWAIT, S_XFER, S_XWAIT, S_FIN, S_END
  } walk_state_t;
endpackage

// File: rtl/pgdma_regs.sv
module pgdma_regs
  import pgdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [CHW-1:0]    act_chan,
  output logic [DW-1:0]     sel_ctl,
  output logic [DW-1:0]     sel_cnt,
  output logic [DW-1:0]     sel_adr,
  output logic [DW-1:0]     tbl_base,
  output logic [DW-1:0]     tbl_limit,
  output logic [NCH-1:0]    err_src,
  input  logic              st_clr,
  input  logic              st_merr,
  input  logic              st_aerr,
  input  logic              st_tc,
  input  logic [DW-1:0]     st_sub
);
  localparam logic [DW-1:0] FLAG_MASK = DW'((1 << CB_TC) | (1 << CB_MERR) | (1 << CB_AERR));

  logic [DW-1:0] aux_q [NCH];
  logic [DW-1:0] ctl_q [NCH];
  logic [DW-1:0] cnt_q [NCH];
  logic [DW-1:0] adr_q [NCH];
  logic [DW-1:0] base_q, limit_q;
  logic [NCH-1:0] err_q;

  logic [REG_AW-1:0] rel;
  logic              ch_hit;
  logic [CHW-1:0]    ch_idx;
  logic [1:0]        word;

  assign rel    = reg_addr - REG_AW'(CH_BASE);
  assign ch_hit = (reg_addr >= REG_AW'(CH_BASE)) &&
                  ({1'b0, rel} < (REG_AW+1)'(NCH << CH_STRIDE_B));
  assign ch_idx = rel[CH_STRIDE_B +: CHW];
  assign word   = rel[4:3];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit, mine;
    logic [DW-1:0] setv;
    assign hit  = reg_we && ch_hit && (ch_idx == CHW'(g));
    assign mine = (act_chan == CHW'(g));
    assign setv = (st_tc   ? DW'(1 << CB_TC)   : '0) |
                  (st_merr ? DW'(1 << CB_MERR) : '0) |
                  (st_aerr ? DW'(1 << CB_AERR) : '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        aux_q[g] <= '0;
        ctl_q[g] <= '0;
        cnt_q[g] <= '0;
        adr_q[g] <= '0;
      end else begin
        if (hit && word == 2'd0) aux_q[g] <= reg_wdata;
        if (mine && (st_clr || st_tc || st_merr || st_aerr))
          ctl_q[g] <= (st_clr ? (ctl_q[g] & ~FLAG_MASK) : ctl_q[g]) | setv;
        else if (hit && word == 2'd1)
          ctl_q[g] <= reg_wdata;
        if (mine && st_tc)
          cnt_q[g] <= cnt_q[g] - st_sub;
        else if (hit && word == 2'd2)
          cnt_q[g] <= reg_wdata;
        if (hit && word == 2'd3) adr_q[g] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      err_q   <= '0;
    end else begin
      if (reg_we && reg_addr[REG_AW-1:3] == (REG_AW-3)'(OFF_TBASE >> 3))  base_q  <= reg_wdata;
      if (reg_we && reg_addr[REG_AW-1:3] == (REG_AW-3)'(OFF_TLIMIT >> 3)) limit_q <= reg_wdata;
      if (st_merr) err_q <= err_q | (NCH'(1) << act_chan);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (ch_hit) begin
      case (word)
        2'd0:    reg_rdata = aux_q[ch_idx];
        2'd1:    reg_rdata = ctl_q[ch_idx];
        2'd2:    reg_rdata = cnt_q[ch_idx];
        default: reg_rdata = adr_q[ch_idx];
      endcase
    end else if (reg_addr[REG_AW-1:3] == (REG_AW-3)'(OFF_TBASE >> 3))  reg_rdata = base_q;
    else if (reg_addr[REG_AW-1:3] == (REG_AW-3)'(OFF_TLIMIT >> 3)) reg_rdata = limit_q;
    else if (reg_addr[REG_AW-1:3] == (REG_AW-3)'(OFF_ERRSRC >> 3)) reg_rdata = DW'(err_q);
  end

  assign sel_ctl   = ctl_q[act_chan];
  assign sel_cnt   = cnt_q[act_chan];
  assign sel_adr   = adr_q[act_chan];
  assign tbl_base  = base_q;
  assign tbl_limit = limit_q;
  assign err_src   = err_q;
endmodule

// File: rtl/pgdma_pager.sv
module pgdma_pager
  import pgdma_pkg::*;
#(
  parameter int DW = 32,
  parameter int PB = 12
) (
  input  logic [DW-1:0] laddr,
  input  logic [DW-1:0] rem,
  input  logic [DW-1:0] tbl_base,
  input  logic [DW-1:0] tbl_limit,
  input  logic [DW-1:0] frame,
  output logic          in_range,
  output logic [DW-1:0] entry_addr,
  output logic [PB:0]   chunk,
  output logic [DW-1:0] phys
);
  localparam int ESH = $clog2(ENTRY_BYTES);
  localparam logic [DW-1:0] ADDR_MASK = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] idx, n_entries;
  logic [PB-1:0] off;
  logic [PB:0]   room;

  assign idx        = laddr >> PB;
  assign n_entries  = tbl_limit >> ESH;
  assign in_range   = idx < n_entries;
  assign entry_addr = (tbl_base + (idx << ESH)) & ADDR_MASK;
  assign off        = laddr[PB-1:0];
  assign room       = (PB+1)'(1 << PB) - {1'b0, off};
  assign chunk      = (rem < {{(DW-PB-1){1'b0}}, room}) ? rem[PB:0] : room;
  assign phys       = frame + {{(DW-PB){1'b0}}, off};
endmodule

// File: rtl/pgdma_walker.sv
module pgdma_walker
  import pgdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 32,
  parameter int PB  = 12,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [CHW-1:0] req_chan,
  input  logic [DW-1:0]  req_len,
  input  logic           req_write,
  output logic [CHW-1:0] act_chan,
  input  logic [DW-1:0]  sel_ctl,
  input  logic [DW-1:0]  sel_cnt,
  input  logic [DW-1:0]  sel_adr,
  input  logic [DW-1:0]  tbl_base,
  input  logic [DW-1:0]  tbl_limit,
  output logic           st_clr,
  output logic           st_merr,
  output logic           st_aerr,
  output logic           st_tc,
  output logic [DW-1:0]  st_sub,
  output logic           mem_req,
  output logic           mem_fetch,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [PB:0]    mem_len,
  input  logic           mem_gnt,
  input  logic           mem_rvalid,
  input  logic           mem_rerr,
  input  logic [DW-1:0]  mem_rdata,
  output logic           done,
  output logic [DW-1:0]  done_bytes,
  output logic           done_abort
);
  walk_state_t   st_q;
  logic [CHW-1:0] chan_q;
  logic          wr_q, abort_q;
  logic [DW-1:0] len_q, laddr_q, rem_q, moved_q, frame_q;

  logic          in_range, reject;
  logic [DW-1:0] entry_addr, phys;
  logic [PB:0]   chunk;

  pgdma_pager #(.DW(DW), .PB(PB)) u_pager (
    .laddr(laddr_q), .rem(rem_q), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .frame(frame_q), .in_range(in_range), .entry_addr(entry_addr),
    .chunk(chunk), .phys(phys)
  );

  // direction: req_write=1 means device->memory, control bit set means memory->device
  assign reject = !sel_ctl[CB_EN] || (wr_q == sel_ctl[CB_M2D]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      chan_q  <= '0;
      wr_q    <= 1'b0;
      abort_q <= 1'b0;
      len_q   <= '0;
      laddr_q <= '0;
      rem_q   <= '0;
      moved_q <= '0;
      frame_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          chan_q <= req_chan;
          wr_q   <= req_write;
          len_q  <= req_len;
          st_q   <= S_CHECK;
        end
        S_CHECK: begin
          moved_q <= '0;
          abort_q <= reject;
          if (reject) st_q <= S_END;
          else begin
            rem_q   <= (len_q < sel_cnt) ? len_q : sel_cnt;
            laddr_q <= sel_adr;
            st_q    <= S_PAGE;
          end
        end
        S_PAGE:  st_q <= (rem_q == '0 || !in_range) ? S_FIN : S_FETCH;
        S_FETCH: if (mem_gnt) st_q <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          if (mem_rerr) begin
            abort_q <= 1'b1;
            st_q    <= S_END;
          end else begin
            frame_q <= mem_rdata;
            st_q    <= S_XFER;
          end
        end
        S_XFER:  if (mem_gnt) st_q <= S_XWAIT;
        S_XWAIT: if (mem_rvalid) begin
          laddr_q <= laddr_q + {{(DW-PB-1){1'b0}}, chunk};
          rem_q   <= rem_q   - {{(DW-PB-1){1'b0}}, chunk};
          moved_q <= moved_q + {{(DW-PB-1){1'b0}}, chunk};
          st_q    <= S_PAGE;
        end
        S_FIN:   st_q <= S_END;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st_q == S_IDLE);
  assign act_chan   = chan_q;
  assign st_clr     = (st_q == S_CHECK);
  assign st_merr    = (st_q == S_CHECK) && reject;
  assign st_aerr    = (st_q == S_FWAIT) && mem_rvalid && mem_rerr;
  assign st_tc      = (st_q == S_FIN);
  assign st_sub     = moved_q;

  assign mem_req    = (st_q == S_FETCH) || (st_q == S_XFER);
  assign mem_fetch  = (st_q == S_FETCH);
  assign mem_we     = (st_q == S_XFER) && wr_q;
  assign mem_addr   = (st_q == S_FETCH) ? entry_addr : phys;
  assign mem_len    = (st_q == S_FETCH) ? (PB+1)'(ENTRY_BYTES) : chunk;

  assign done       = (st_q == S_END);
  assign done_bytes = moved_q;
  assign done_abort = abort_q;
endmodule

// File: rtl/pgdma_engine.sv
module pgdma_engine
  import pgdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 32,
  parameter int PB  = 12,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHW-1:0]    req_chan,
  input  logic [DW-1:0]     req_len,
  input  logic              req_write,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_fetch,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [PB:0]       mem_len,
  input  logic              mem_rvalid,
  input  logic              mem_rerr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              done,
  output logic [DW-1:0]     done_bytes,
  output logic              done_abort,
  output logic [NCH-1:0]    nmi_src
);
  logic [CHW-1:0] act_chan;
  logic [DW-1:0]  sel_ctl, sel_cnt, sel_adr, tbl_base, tbl_limit, st_sub;
  logic           st_clr, st_merr, st_aerr, st_tc;

  pgdma_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_chan(act_chan),
    .sel_ctl(sel_ctl), .sel_cnt(sel_cnt), .sel_adr(sel_adr),
    .tbl_base(tbl_base), .tbl_limit(tbl_limit), .err_src(nmi_src),
    .st_clr(st_clr), .st_merr(st_merr), .st_aerr(st_aerr), .st_tc(st_tc),
    .st_sub(st_sub)
  );

  pgdma_walker #(.NCH(NCH), .DW(DW), .PB(PB)) u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_len(req_len), .req_write(req_write),
    .act_chan(act_chan), .sel_ctl(sel_ctl), .sel_cnt(sel_cnt), .sel_adr(sel_adr),
    .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .st_clr(st_clr), .st_merr(st_merr), .st_aerr(st_aerr), .st_tc(st_tc),
    .st_sub(st_sub), .mem_req(mem_req), .mem_fetch(mem_fetch), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rerr(mem_rerr), .mem_rdata(mem_rdata),
    .done(done), .done_bytes(done_bytes), .done_abort(done_abort)
  );
endmodule

// File: rtl/pgdma_checker.sv
module pgdma_checker #(
  parameter int NCH = 8,
  parameter int DW  = 32,
  parameter int PB  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           mem_req,
  input logic           mem_gnt,
  input logic           mem_fetch,
  input logic           mem_we,
  input logic [DW-1:0]  mem_addr,
  input logic [PB:0]    mem_len,
  input logic           done,
  input logic [NCH-1:0] nmi_src
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || done) |-> !req_ready);

  a_r11_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)
                               && $stable(mem_fetch) && $stable(mem_we)));

  a_r6_entry_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_fetch) |-> (!mem_addr[DW-1] && !mem_we && mem_len == (PB+1)'(8)));

  a_r7_chunk_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_fetch) |-> (mem_len != '0 && mem_len <= (PB+1)'(1 << PB)));

  a_r4_src_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(nmi_src) & ~nmi_src) == '0));
endmodule

bind pgdma_engine pgdma_checker #(.NCH(NCH), .DW(DW), .PB(PB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_gnt(mem_gnt), .mem_fetch(mem_fetch), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_len(mem_len), .done(done), .nmi_src(nmi_src)
);

// File: tb/pgdma_engine_bench.sv
module pgdma_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [2:0]  req_chan = '0;
  logic [31:0] req_len = '0;
  logic        mem_req, mem_gnt = 1'b0, mem_fetch, mem_we;
  logic [31:0] mem_addr;
  logic [12:0] mem_len;
  logic        mem_rvalid = 1'b0, mem_rerr = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, done_abort;
  logic [31:0] done_bytes;
  logic [7:0]  nmi_src;

  pgdma_engine u_pgdma_engine (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;

  // memory model log
  logic [31:0] f_log [16];
  logic [31:0] d_addr [16];
  logic [12:0] d_len [16];
  logic        d_we [16];
  int n_f = 0, n_d = 0, phase = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic        cur_fetch;
  logic [31:0] cur_addr;

  function automatic logic [31:0] frame_of(input logic [31:0] a);
    return 32'h0040_0000 + (a << 9);
  endfunction

  always @(negedge clk) begin
    if (phase == 1) begin
      mem_gnt <= 1'b0; mem_rvalid <= 1'b1;
      mem_rdata <= cur_fetch ? frame_of(cur_addr) : 32'h0;
      mem_rerr  <= cur_fetch && (cur_addr == err_addr);
      phase = 2;
    end else if (phase == 2) begin
      mem_rvalid <= 1'b0; mem_rerr <= 1'b0; phase = 0;
    end else if (mem_req) begin
      mem_gnt <= 1'b1; cur_fetch = mem_fetch; cur_addr = mem_addr;
      if (mem_fetch) begin if (n_f < 16) f_log[n_f] = mem_addr; n_f++; end
      else if (n_d < 16) begin d_addr[n_d] = mem_addr; d_len[n_d] = mem_len; d_we[n_d] = mem_we; n_d++; end
      else n_d++;
      phase = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [8:0] ch_off(input int ch, input int k);
    return 9'(32'h100 + 32*ch + 8*k);
  endfunction

  logic [31:0] got_bytes;
  logic        got_abort;

  // issue a request; optionally raise a stray request while busy
  task automatic run(input int ch, input logic [31:0] len, input logic w, input bit stray);
    n_f = 0; n_d = 0;
    @(negedge clk); req_valid = 1'b1; req_chan = 3'(ch); req_len = len; req_write = w;
    @(negedge clk); req_valid = 1'b0;
    if (stray) begin
      req_valid = 1'b1; req_chan = 3'd6; req_len = 32'h10; req_write = 1'b1;
      chk("R3 ready low while busy", {31'b0, req_ready}, 32'h0);
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    for (int t = 0; t < 2000 && !done; t++) @(negedge clk);
    chk("R10 done seen", {31'b0, done}, 32'h1);
    got_bytes = done_bytes; got_abort = done_abort;
    @(negedge clk);
    chk("R10 done one cycle", {31'b0, done}, 32'h0);
    chk("R3 ready after done", {31'b0, req_ready}, 32'h1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 ready", {31'b0, req_ready}, 32'h1);
    chk("R1 done", {31'b0, done}, 32'h0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
    chk("R1 nmi", {24'b0, nmi_src}, 32'h0);
    rd(ch_off(0, 1), v); chk("R1 ctl0", v, 32'h0);
    rd(9'h040, v); chk("R1 base", v, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(9'h040, 32'h1234_5678); wr(9'h048, 32'hABCD_0008);
    for (int k = 0; k < 4; k++) wr(ch_off(7, k), 32'hC0DE_0000 + 32'(k));
    rd(9'h040, v); chk("R2 base", v, 32'h1234_5678);
    rd(9'h048, v); chk("R2 limit", v, 32'hABCD_0008);
    for (int k = 0; k < 4; k++) begin rd(ch_off(7, k), v); chk("R2 chan7 word", v, 32'hC0DE_0000 + 32'(k)); end
    rd(ch_off(6, 1), v); chk("R2 no alias chan6", v, 32'h0);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    wr(ch_off(0, 1), 32'h0000_0100); wr(ch_off(0, 2), 32'h40);
    run(0, 32'h10, 1'b1, 0);
    chk("R4 disabled abort", {31'b0, got_abort}, 32'h1);
    chk("R4 disabled bytes", got_bytes, 32'h0);
    chk("R4 disabled no mem", 32'(n_f + n_d), 32'h0);
    rd(ch_off(0, 1), v); chk("R4 disabled ctl", v, 32'h0000_0200);
    rd(ch_off(0, 2), v); chk("R4 disabled count", v, 32'h40);
    wr(ch_off(1, 1), 32'h3); wr(ch_off(1, 2), 32'h40);
    run(1, 32'h10, 1'b1, 0);
    chk("R4 direction abort", {31'b0, got_abort}, 32'h1);
    rd(ch_off(1, 1), v); chk("R4 direction ctl", v, 32'h0000_0203);
    chk("R4 nmi bits", {24'b0, nmi_src}, 32'h3);
    rd(9'h050, v); chk("R2 errsrc readback", v, 32'h3);
  endtask

  task automatic t_single;
    logic [31:0] v;
    wr(9'h040, 32'h1000); wr(9'h048, 32'h100);
    wr(ch_off(6, 1), 32'h0);
    wr(ch_off(2, 1), 32'h1); wr(ch_off(2, 2), 32'h300); wr(ch_off(2, 3), 32'h5010);
    run(2, 32'h100, 1'b1, 1);
    chk("R6 single fetch count", 32'(n_f), 32'd1);
    chk("R6 single entry addr", f_log[0], 32'h1028);
    chk("R7 single data addr", d_addr[0], frame_of(32'h1028) + 32'h10);
    chk("R7 single data len", {19'b0, d_len[0]}, 32'h100);
    chk("R7 single we", {31'b0, d_we[0]}, 32'h1);
    chk("R5 single bytes", got_bytes, 32'h100);
    rd(ch_off(2, 2), v); chk("R5 single count", v, 32'h200);
    rd(ch_off(2, 1), v); chk("R5 single ctl", v, 32'h101);
    chk("R3 stray ignored nmi", {31'b0, nmi_src[6]}, 32'h0);
    rd(ch_off(6, 1), v); chk("R3 stray ignored ctl6", v, 32'h0);
  endtask

  task automatic t_multi;
    logic [31:0] v;
    wr(ch_off(3, 1), 32'h703); wr(ch_off(3, 2), 32'h1800); wr(ch_off(3, 3), 32'h7F00);
    run(3, 32'h4000, 1'b0, 0);
    chk("R6 multi fetches", 32'(n_f), 32'd3);
    chk("R6 multi entry0", f_log[0], 32'h1038);
    chk("R6 multi entry2", f_log[2], 32'h1048);
    chk("R7 multi chunks", 32'(n_d), 32'd3);
    chk("R7 head len", {19'b0, d_len[0]}, 32'h100);
    chk("R7 head addr", d_addr[0], frame_of(32'h1038) + 32'hF00);
    chk("R7 mid len", {19'b0, d_len[1]}, 32'h1000);
    chk("R7 mid addr", d_addr[1], frame_of(32'h1040));
    chk("R7 tail len", {19'b0, d_len[2]}, 32'h700);
    chk("R7 read dir", {31'b0, d_we[1]}, 32'h0);
    chk("R5 clamp bytes", got_bytes, 32'h1800);
    rd(ch_off(3, 2), v); chk("R5 clamp count", v, 32'h0);
    rd(ch_off(3, 1), v); chk("R4 flags cleared then tc", v, 32'h103);
  endtask

  task automatic t_limit;
    logic [31:0] v;
    wr(9'h048, 32'h48);
    wr(ch_off(4, 1), 32'h1); wr(ch_off(4, 2), 32'h3000); wr(ch_off(4, 3), 32'h8800);
    run(4, 32'h2000, 1'b1, 0);
    chk("R8 limit fetches", 32'(n_f), 32'd1);
    chk("R8 limit chunks", 32'(n_d), 32'd1);
    chk("R8 limit bytes", got_bytes, 32'h800);
    chk("R8 limit not abort", {31'b0, got_abort}, 32'h0);
    rd(ch_off(4, 2), v); chk("R8 limit count", v, 32'h2800);
    rd(ch_off(4, 1), v); chk("R8 limit ctl", v, 32'h101);
  endtask

  task automatic t_fetch_err;
    logic [31:0] v;
    wr(9'h040, 32'h8000_0000); wr(9'h048, 32'h1000);
    wr(ch_off(5, 1), 32'h1); wr(ch_off(5, 2), 32'h2000); wr(ch_off(5, 3), 32'h0F00);
    err_addr = 32'h8;
    run(5, 32'h1000, 1'b1, 0);
    err_addr = 32'hFFFF_FFFF;
    chk("R6 masked entry", f_log[0], 32'h0);
    chk("R9 second fetch", f_log[1], 32'h8);
    chk("R9 abort", {31'b0, got_abort}, 32'h1);
    chk("R9 bytes before", got_bytes, 32'h100);
    chk("R9 chunks", 32'(n_d), 32'd1);
    rd(ch_off(5, 2), v); chk("R9 count kept", v, 32'h2000);
    rd(ch_off(5, 1), v); chk("R9 ctl", v, 32'h401);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    run(2, 32'h0, 1'b1, 0);
    chk("R5 zero bytes", got_bytes, 32'h0);
    chk("R5 zero no mem", 32'(n_f + n_d), 32'h0);
    rd(ch_off(2, 1), v); chk("R5 zero ctl", v, 32'h101);
    rd(ch_off(2, 2), v); chk("R5 zero count", v, 32'h200);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset; t_regmap; t_reject; t_single; t_multi; t_limit; t_fetch_err; t_zero;
      end
      begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule